// File: doc/BRIEF.md
# Dual-Rate Multi-Queue Write Front End

This block is the write side of a multi-queue FIFO. Each queue owns a write port made of a clock, an active-low write enable, an active-low chip select and a data bus. It captures words into that queue's storage. A write is accepted only when both strobes are low at a rising clock edge. In single-rate operation one word is taken per rising edge. In double-rate operation the rising-edge word is followed by a second word taken on the next falling edge of the same clock.

The data-rate choice and the quad/dual queue arrangement are both loaded while the synchronous master reset is held low, and they stay fixed until the next reset. In the dual arrangement only the even-numbered ports are live. Each queue keeps a word count and a full flag. A combinational storage tap lets the read side, or a bench, fetch any stored word by queue and index.

Top module: `ddr_sdr_wport`

## Requirements
- R1: The rate select (1 = double rate, 0 = single rate) and the arrangement select (1 = quad, 0 = dual) are taken only at rising edges where `mrst_n` is low. Changing them after reset has no effect on how words are captured.
- R2: In single-rate mode, each rising edge at which a queue's `wen_n` and `wcs_n` are both low adds exactly one word, the data present at that edge. The count rises by one.
- R3: In double-rate mode, an enabled rising edge adds the rising-edge data and then the data present at the following falling edge. They are stored in that order, and the count rises by two at that rising edge.
- R4: The strobes are looked at only on rising edges. Changing them between a rising edge and the next falling edge neither starts nor cancels a falling-edge word.
- R5: `wcs_n` acts as a second, independent write enable. If either strobe is high at a rising edge, nothing is written for that cycle.
- R6: In quad mode all four ports write their own queues independently. In dual mode the inputs of ports 1 and 3 are ignored and those queues stay empty.
- R7: A queue's full flag is high exactly when its count equals DEPTH. A write attempted while full is dropped, and the count does not change.
- R8: In double-rate mode, if the rising-edge word fills the queue, the falling-edge word of that cycle is dropped.
- R9: Master reset sets every count to zero and every full flag low.
- R10: The tap returns, for queue `tap_q` and index `tap_addr`, the word accepted at that position (0 = first after reset). A falling-edge word appears on the tap from the next rising edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | NQ | Write clock, one per queue |
| mrst_n | input | 1 | Master reset, active low, synchronous to each write clock |
| rate_ddr | input | 1 | Rate select, loaded during reset (1 = double rate) |
| quad_mode | input | 1 | Arrangement select, loaded during reset (1 = quad, 0 = dual) |
| wen_n | input | NQ | Active-low write enable per queue |
| wcs_n | input | NQ | Active-low chip select per queue |
| wr_data | input | NQ*DW | Write data, queue q in bits [q*DW +: DW] |
| tap_q | input | QW | Queue selected for the storage tap |
| tap_addr | input | AW | Word index for the storage tap |
| tap_data | output | DW | Stored word at the selected queue and index |
| word_cnt | output | NQ*CW | Word count per queue, queue q in bits [q*CW +: CW] |
| full | output | NQ | Full flag per queue |

## Verification
A wrong rate or arrangement latch shows up at the first enabled rising edge after reset. The count then moves by the wrong step, or an odd queue in dual mode leaves zero. A falling-edge word that is armed or dropped in error changes the count at that same rising edge, so comparing counts and full flags on every clock finds it within one cycle. Wrong address or data capture, such as a swapped rising/falling order or data taken at the wrong edge, changes no count. It is caught when the tap contents are compared with the reference queue after each phase.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef enum logic {
      RATE_SDR = 1'b0,
      RATE_DDR = 1'b1
   } rate_e;

   typedef enum logic {
      ARR_DUAL = 1'b0,
      ARR_QUAD = 1'b1
   } arr_e;
endpackage

// File: rtl/wp_cfg_latch.sv
module wp_cfg_latch
   import wp_pkg::*;
(
   input  logic  clk,
   input  logic  mrst_n,
   input  logic  rate_in,
   input  logic  quad_in,
   output rate_e rate_q,
   output arr_e  arr_q
);
   // configuration follows the pins only while reset is held
   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         rate_q <= rate_e'(rate_in);
         arr_q  <= arr_e'(quad_in);
      end
   end
endmodule

// File: rtl/wp_edge_gate.sv
module wp_edge_gate (
   input  logic clk,
   input  logic mrst_n,
   input  logic port_on,
   input  logic ddr,
   input  logic wen_n,
   input  logic wcs_n,
   input  logic room,
   input  logic room2,
   output logic rise_ok,
   output logic fall_ok,
   output logic fall_arm
);
   logic strobe;

   assign strobe  = mrst_n && port_on && !wen_n && !wcs_n;
   assign rise_ok = strobe && room;
   assign fall_ok = rise_ok && ddr && room2;

   // decision for the falling edge is frozen at the rising edge
   always_ff @(posedge clk) begin
      if (!mrst_n) fall_arm <= 1'b0;
      else         fall_arm <= fall_ok;
   end

   a_r4_fall_only_ddr: assert property (@(posedge clk) disable iff (!mrst_n)
      fall_arm |-> ddr);
endmodule

// File: rtl/wp_queue_store.sv
module wp_queue_store #(
   parameter int DW    = 10,
   parameter int DEPTH = 6,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          ddr,
   input  logic          rise_ok,
   input  logic          fall_ok,
   input  logic          fall_arm,
   input  logic [DW-1:0] din,
   input  logic [AW-1:0] tap_addr,
   output logic [DW-1:0] tap_data,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          room,
   output logic          room2
);
   logic [DW-1:0] mem [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          full_q;
   logic [AW-1:0] fall_addr_q;
   logic [DW-1:0] fall_data_q;

   assign room  = cnt_q < CW'(DEPTH);
   assign room2 = ({1'b0, cnt_q} + (CW+1)'(1)) < (CW+1)'(DEPTH);
   assign cnt_nxt = cnt_q + CW'(rise_ok) + CW'(fall_ok);

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         cnt_q  <= '0;
         full_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         full_q <= (cnt_nxt == CW'(DEPTH));
      end
   end

   // falling-edge word parks in a holding register
   always_ff @(negedge clk) begin
      if (fall_arm) fall_data_q <= din;
   end

   // both storage writes happen on the rising edge
   always_ff @(posedge clk) begin
      if (fall_arm) mem[fall_addr_q] <= fall_data_q;
      if (rise_ok)  mem[cnt_q[AW-1:0]] <= din;
      if (fall_ok)  fall_addr_q <= AW'(cnt_q + CW'(1));
   end

   always_comb begin
      tap_data = '0;
      if (int'(tap_addr) < DEPTH) tap_data = mem[tap_addr];
   end

   assign cnt  = cnt_q;
   assign full = full_q;

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!mrst_n)
      int'(cnt_q) <= DEPTH);
   a_r7_full_hold: assert property (@(posedge clk) disable iff (!mrst_n)
      full_q |=> $stable(cnt_q));
   a_r7_full_at_depth: assert property (@(posedge clk) disable iff (!mrst_n)
      full_q |-> (int'(cnt_q) == DEPTH));
   a_r3_max_step: assert property (@(posedge clk) disable iff (!mrst_n)
      int'(cnt_q) <= int'($past(cnt_q)) + (ddr ? 2 : 1));
endmodule

// File: rtl/ddr_sdr_wport.sv
module ddr_sdr_wport
   import wp_pkg::*;
#(
   parameter int NQ    = 4,
   parameter int DW    = 10,
   parameter int DEPTH = 6,
   localparam int QW   = $clog2(NQ),
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic [NQ-1:0]    wr_clk,
   input  logic             mrst_n,
   input  logic             rate_ddr,
   input  logic             quad_mode,
   input  logic [NQ-1:0]    wen_n,
   input  logic [NQ-1:0]    wcs_n,
   input  logic [NQ*DW-1:0] wr_data,
   input  logic [QW-1:0]    tap_q,
   input  logic [AW-1:0]    tap_addr,
   output logic [DW-1:0]    tap_data,
   output logic [NQ*CW-1:0] word_cnt,
   output logic [NQ-1:0]    full
);
   if (NQ < 2)    $error("NQ must be at least 2");
   if (NQ % 2)    $error("NQ must be even for the dual arrangement");
   if (DEPTH < 2) $error("DEPTH must be at least 2");
   if (DW < 1)    $error("DW must be positive");

   logic [DW-1:0] q_tap [NQ];

   for (genvar q = 0; q < NQ; q++) begin : g_q
      localparam bit EVEN = (q % 2) == 0;
      rate_e         rate;
      arr_e          arr;
      logic          port_on;
      logic          rise_ok, fall_ok, fall_arm, room, room2;
      logic [CW-1:0] cnt;

      wp_cfg_latch u_cfg (
         .clk     (wr_clk[q]),
         .mrst_n  (mrst_n),
         .rate_in (rate_ddr),
         .quad_in (quad_mode),
         .rate_q  (rate),
         .arr_q   (arr)
      );

      if (EVEN) begin : g_even
         assign port_on = 1'b1;
      end else begin : g_odd
         assign port_on = (arr == ARR_QUAD);
         a_r6_dual_idle: assert property (@(posedge wr_clk[q]) disable iff (!mrst_n)
            (arr == ARR_DUAL) |-> (cnt == '0));
      end

      wp_edge_gate u_gate (
         .clk      (wr_clk[q]),
         .mrst_n   (mrst_n),
         .port_on  (port_on),
         .ddr      (rate == RATE_DDR),
         .wen_n    (wen_n[q]),
         .wcs_n    (wcs_n[q]),
         .room     (room),
         .room2    (room2),
         .rise_ok  (rise_ok),
         .fall_ok  (fall_ok),
         .fall_arm (fall_arm)
      );

      wp_queue_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
         .clk      (wr_clk[q]),
         .mrst_n   (mrst_n),
         .ddr      (rate == RATE_DDR),
         .rise_ok  (rise_ok),
         .fall_ok  (fall_ok),
         .fall_arm (fall_arm),
         .din      (wr_data[q*DW +: DW]),
         .tap_addr (tap_addr),
         .tap_data (q_tap[q]),
         .cnt      (cnt),
         .full     (full[q]),
         .room     (room),
         .room2    (room2)
      );

      assign word_cnt[q*CW +: CW] = cnt;
   end

   always_comb begin
      tap_data = '0;
      if (int'(tap_q) < NQ) tap_data = q_tap[tap_q];
   end
endmodule

// File: tb/ddr_sdr_wport_bench.sv
module ddr_sdr_wport_bench;
   localparam int NQ = 4, DW = 10, DEPTH = 7;
   localparam int QW = 2, AW = 3, CW = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [NQ-1:0]    wr_clk;
   logic             mrst_n = 1'b0, rate_ddr = 1'b0, quad_mode = 1'b1;
   logic [NQ-1:0]    wen_n = '1, wcs_n = '1;
   logic [NQ*DW-1:0] wr_data = '0;
   logic [QW-1:0]    tap_q = '0;
   logic [AW-1:0]    tap_addr = '0;
   logic [DW-1:0]    tap_data;
   logic [NQ*CW-1:0] word_cnt;
   logic [NQ-1:0]    full;

   assign wr_clk = {NQ{clk}};

   ddr_sdr_wport #(.NQ(NQ), .DW(DW), .DEPTH(DEPTH)) u_ddr_sdr_wport (
      .wr_clk(wr_clk), .mrst_n(mrst_n), .rate_ddr(rate_ddr), .quad_mode(quad_mode),
      .wen_n(wen_n), .wcs_n(wcs_n), .wr_data(wr_data), .tap_q(tap_q),
      .tap_addr(tap_addr), .tap_data(tap_data), .word_cnt(word_cnt), .full(full)
   );

   int nchk = 0, nfail = 0, seq = 1;
   int mq [NQ][$];
   bit m_ddr, m_quad;

   task automatic chk(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic cmp_all(string req);
      for (int q = 0; q < NQ; q++) begin
         chk(req, int'(word_cnt[q*CW +: CW]), mq[q].size());
         chk("R7", int'(full[q]), int'(mq[q].size() == DEPTH));
      end
   endtask

   task automatic do_reset(bit rate, bit quad);
      mrst_n = 1'b0; rate_ddr = rate; quad_mode = quad; wen_n = '1; wcs_n = '1;
      repeat (3) @(posedge clk);
      @(negedge clk); mrst_n = 1'b1;
      for (int q = 0; q < NQ; q++) mq[q].delete();
      m_ddr = rate; m_quad = quad;
      #1; cmp_all("R9");
      rate_ddr = ~rate; quad_mode = ~quad;   // R1: later changes must not matter
   endtask

   // rising-edge strobes, then a strobe change before the falling edge
   task automatic step(string req, logic [NQ-1:0] wen, logic [NQ-1:0] wcs, logic [NQ-1:0] wen_after);
      int rw [NQ];
      int fw [NQ];
      @(negedge clk); #1;
      wen_n = wen; wcs_n = wcs;
      for (int q = 0; q < NQ; q++) begin
         rw[q] = (seq * 8 + q * 2) & 10'h3ff;
         fw[q] = rw[q] + 1;
         wr_data[q*DW +: DW] = DW'(rw[q]);
      end
      seq++;
      @(posedge clk); #1;
      for (int q = 0; q < NQ; q++) wr_data[q*DW +: DW] = DW'(fw[q]);
      wen_n = wen_after;
      for (int q = 0; q < NQ; q++) begin
         if ((m_quad || (q % 2 == 0)) && !wen[q] && !wcs[q]) begin
            if (mq[q].size() < DEPTH) mq[q].push_back(rw[q]);
            if (m_ddr && mq[q].size() < DEPTH) mq[q].push_back(fw[q]);
         end
      end
      cmp_all(req);
   endtask

   task automatic check_mem(int q);
      step("R4", '1, '1, '1);   // idle cycle commits any falling-edge word
      for (int i = 0; i < mq[q].size(); i++) begin
         tap_q = QW'(q); tap_addr = AW'(i); #1;
         chk("R10", int'(tap_data), mq[q][i]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      // single rate, quad
      do_reset(1'b0, 1'b1);
      step("R2", 4'b0000, 4'b0000, 4'b1111);        // R1: rate pin now high, still one word
      step("R5", 4'b0100, 4'b0010, 4'b0000);        // q1 cs high, q2 wen high
      step("R4", 4'b1111, 4'b1111, 4'b0000);        // enable only after rise: nothing
      for (int k = 0; k < 8; k++) step("R7", 4'b1110, 4'b0000, 4'b1111);
      for (int q = 0; q < NQ; q++) check_mem(q);

      // double rate, dual (reset while q0 full)
      do_reset(1'b1, 1'b0);
      step("R6", 4'b0000, 4'b0000, 4'b1111);        // R3 and R4: fall still written
      step("R4", 4'b1111, 4'b1111, 4'b0000);        // late enable starts nothing
      step("R3", 4'b1110, 4'b0000, 4'b0000);
      step("R3", 4'b1110, 4'b0000, 4'b1111);
      step("R8", 4'b1110, 4'b0000, 4'b0000);        // 6 -> 7, falling word dropped
      step("R7", 4'b1110, 4'b0000, 4'b0000);        // full: dropped
      check_mem(0);
      check_mem(2);

      // double rate, quad
      do_reset(1'b1, 1'b1);
      step("R6", 4'b0000, 4'b0000, 4'b0000);
      step("R5", 4'b1010, 4'b0110, 4'b0000);        // only q0 writes
      for (int q = 0; q < NQ; q++) check_mem(q);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule